// File: doc/BRIEF.md
# Configuration Bus Router

This block sits at the upstream side of a virtual bridge port. It decides what happens to each configuration request that arrives for that port. It holds three bus number registers, named primary, secondary and subordinate, which are loaded through a small register write port. Each request carries a target bus number and a device number. One clock after the request is accepted, the block returns a 2-bit routing code with one of four outcomes:

- The request goes onto the link as a Type 0 access, for the bus directly behind the port.
- The request is passed on unchanged as a Type 1 access, for a bus deeper in the hierarchy.
- The request is master-aborted, because a Type 0 access names a device other than zero.
- The request is not claimed, because it belongs somewhere else.

Every master abort sets a sticky status flag. That flag stays set until software writes a one to clear it. A register write takes priority over a request in the same cycle: the request is held off by `reqReady` and is taken once the write is done. The primary bus number is kept and driven out so that the inbound decode logic next to this block can use it. It does not take part in this block's own routing decision.

Top module: `cfgrt_router`

## Requirements
- R1: After reset, all three bus number outputs are 0, `abortSticky` is 0 and `rspValid` is 0.
- R2: A write with `regWrEn` high loads `regWrData` into the primary (`regSel`=0), secondary (`regSel`=1) or subordinate (`regSel`=2) register. The new value appears on `priBus`, `secBus` or `subBus` from the next clock.
- R3: An accepted request whose bus equals the secondary number and whose device is 0 returns `rspCode` 2'b01 (Type 0).
- R4: An accepted request whose bus is above the secondary number and at or below the subordinate number returns `rspCode` 2'b10 (Type 1) for any device number. Both ends of the window are included.
- R5: Any other accepted request returns `rspCode` 2'b00 (not claimed). This includes a bus equal to the primary number when that bus is outside the window.
- R6: When the subordinate number is below the secondary number, only a bus that equals the secondary number is claimed.
- R7: An accepted request whose bus equals the secondary number and whose device is not 0 returns `rspCode` 2'b11 (master abort) and sets `abortSticky`.
- R8: `rspValid` is high in exactly the cycle after each cycle in which `reqValid` and `reqReady` are both high. Back-to-back requests get back-to-back responses.
- R9: `reqReady` is low in any cycle with `regWrEn` high. A request held over such a cycle is classified later against the updated registers.
- R10: `abortSticky` stays set until a write with `regSel`=3 and `regWrData` bit 0 equal to 1 clears it. A write with bit 0 equal to 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqBus | input | BUS_W | Target bus number of the request |
| reqDev | input | DEV_W | Target device number of the request |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 primary, 1 secondary, 2 subordinate, 3 status |
| regWrData | input | BUS_W | Write data; for the status register, bit 0 set clears the flag |
| rspValid | output | 1 | Routing result valid |
| rspCode | output | 2 | 00 not claimed, 01 Type 0, 10 Type 1, 11 master abort |
| abortSticky | output | 1 | Sticky received-master-abort flag |
| priBus | output | BUS_W | Primary bus number |
| secBus | output | BUS_W | Secondary bus number |
| subBus | output | BUS_W | Subordinate bus number |

## Verification
The bench builds the block with its default 8-bit bus numbers and 5-bit device numbers. With those widths, both ends of the bus range, 0 and 255, can be used as window edges and as request targets. A full sweep of all 256 bus values against one programmed window therefore covers every comparison outcome. The 5-bit device field lets the bench use the largest device number, 31, on both forwarded and aborted requests.

// File: rtl/cfgrt_pkg.sv
package cfgrt_pkg;

  // Routing result returned with every accepted request.
  typedef enum logic [1:0] {
    RT_NOCLAIM = 2'b00,
    RT_TYPE0   = 2'b01,
    RT_TYPE1   = 2'b10,
    RT_ABORT   = 2'b11
  } routeCode_e;

  // Register select values on the write port.
  localparam logic [1:0] SEL_PRI  = 2'd0;
  localparam logic [1:0] SEL_SEC  = 2'd1;
  localparam logic [1:0] SEL_SUB  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;
  localparam int unsigned NUM_BUSREG = 3;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic                  accept;
    logic [NUM_BUSREG-1:0] wrBus;     // [0] primary, [1] secondary, [2] subordinate
    logic                  clrAbort;
  } ctlStrobes_t;

endpackage

// File: rtl/cfgrt_ctrl.sv
module cfgrt_ctrl
  import cfgrt_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic             reqValid,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [BUS_W-1:0] regWrData,
  output logic             reqReady,
  output ctlStrobes_t      strobes
);

  // A register write holds requests off, so a request never races a write.
  always_comb begin
    reqReady         = !regWrEn;
    strobes.accept   = reqValid && !regWrEn;
    strobes.clrAbort = regWrEn && (regSel == SEL_STAT) && regWrData[0];
  end

  for (genvar g = 0; g < NUM_BUSREG; g++) begin : g_wrDec
    assign strobes.wrBus[g] = regWrEn && (regSel == 2'(g));
  end

endmodule

// File: rtl/cfgrt_datapath.sv
module cfgrt_datapath
  import cfgrt_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [BUS_W-1:0] reqBus,
  input  logic [DEV_W-1:0] reqDev,
  input  logic [BUS_W-1:0] regWrData,
  output logic             rspValid,
  output logic [1:0]       rspCode,
  output logic             abortSticky,
  output logic [BUS_W-1:0] priBus,
  output logic [BUS_W-1:0] secBus,
  output logic [BUS_W-1:0] subBus
);

  logic [BUS_W-1:0] busReg [NUM_BUSREG];

  for (genvar g = 0; g < NUM_BUSREG; g++) begin : g_busReg
    always_ff @(posedge clk) begin
      if (!rstN)                busReg[g] <= '0;
      else if (strobes.wrBus[g]) busReg[g] <= regWrData;
    end
  end

  assign priBus = busReg[0];
  assign secBus = busReg[1];
  assign subBus = busReg[2];

  // Classification of the request in the acceptance cycle.
  logic       hitSec, inWindow;
  routeCode_e nextCode;

  always_comb begin
    hitSec   = (reqBus == secBus);
    inWindow = (reqBus > secBus) && (reqBus <= subBus);
    if (hitSec)        nextCode = (reqDev == '0) ? RT_TYPE0 : RT_ABORT;
    else if (inWindow) nextCode = RT_TYPE1;
    else               nextCode = RT_NOCLAIM;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspCode     <= RT_NOCLAIM;
      abortSticky <= 1'b0;
    end else begin
      rspValid <= strobes.accept;
      if (strobes.accept) rspCode <= nextCode;
      if (strobes.accept && nextCode == RT_ABORT) abortSticky <= 1'b1;
      else if (strobes.clrAbort)                  abortSticky <= 1'b0;
    end
  end

  // R3: a Type 0 result comes from an exact secondary match with device 0.
  assert_type0_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == RT_TYPE0) |-> ($past(reqBus) == $past(secBus) && $past(reqDev) == '0));

  // R4: a Type 1 result lies strictly above secondary and within subordinate.
  assert_type1_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == RT_TYPE1) |-> ($past(reqBus) > $past(secBus) && $past(reqBus) <= $past(subBus)));

  // R5: an unclaimed result never matches the secondary bus.
  assert_noclaim_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == RT_NOCLAIM) |-> ($past(reqBus) != $past(secBus)));

  // R7: an abort result is reflected in the sticky flag.
  assert_abort_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == RT_ABORT) |-> abortSticky);

  // R10: the flag only drops after a clearing write.
  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(abortSticky) && !$past(strobes.clrAbort)) |-> abortSticky);

endmodule

// File: rtl/cfgrt_router.sv
module cfgrt_router
  import cfgrt_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DEV_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [BUS_W-1:0] reqBus,
  input  logic [DEV_W-1:0] reqDev,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [BUS_W-1:0] regWrData,
  output logic             rspValid,
  output logic [1:0]       rspCode,
  output logic             abortSticky,
  output logic [BUS_W-1:0] priBus,
  output logic [BUS_W-1:0] secBus,
  output logic [BUS_W-1:0] subBus
);

  ctlStrobes_t strobes;

  cfgrt_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .reqValid  (reqValid),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .reqReady  (reqReady),
    .strobes   (strobes)
  );

  cfgrt_datapath #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqBus      (reqBus),
    .reqDev      (reqDev),
    .regWrData   (regWrData),
    .rspValid    (rspValid),
    .rspCode     (rspCode),
    .abortSticky (abortSticky),
    .priBus      (priBus),
    .secBus      (secBus),
    .subBus      (subBus)
  );

  // R8: each handshake gives exactly one response in the next cycle.
  assert_rsp_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);
  assert_rsp_has_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady));

endmodule

// File: tb/cfgrt_router_tb.sv
module cfgrt_router_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [7:0] reqBus = '0;
  logic [4:0] reqDev = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic       rspValid;
  logic [1:0] rspCode;
  logic       abortSticky;
  logic [7:0] priBus, secBus, subBus;

  always #4 clk = ~clk;

  cfgrt_router u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBus(reqBus), .reqDev(reqDev), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .rspValid(rspValid), .rspCode(rspCode),
    .abortSticky(abortSticky), .priBus(priBus), .secBus(secBus), .subBus(subBus)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural reference state.
  int mPri = 0, mSec = 0, mSub = 0, mSticky = 0, mRv = 0, mCode = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int classify(input int bus, input int dev);
    if (bus == mSec) return (dev == 0) ? 1 : 3;
    if (bus > mSec && bus <= mSub) return 2;
    return 0;
  endfunction

  // One cycle: drive after a falling edge, model at the rising edge, compare at the next falling edge.
  task automatic step(input bit v, input int bus, input int dev, input bit we,
                      input int sel, input int wd, input string tag);
    bit acc;
    reqValid = v; reqBus = bus[7:0]; reqDev = dev[4:0];
    regWrEn = we; regSel = sel[1:0]; regWrData = wd[7:0];
    #1;
    chk(reqReady == !we, "R9", "reqReady", int'(reqReady), int'(!we));
    @(posedge clk);
    acc = v && !we;
    mRv = acc;
    if (acc) begin
      mCode = classify(bus, dev);
      if (mCode == 3) mSticky = 1;
    end
    if (we) begin
      case (sel)
        0: mPri = wd & 255;
        1: mSec = wd & 255;
        2: mSub = wd & 255;
        default: if (wd % 2 == 1) mSticky = 0;
      endcase
    end
    @(negedge clk);
    chk(int'(rspValid) == mRv, tag, "rspValid", int'(rspValid), mRv);
    if (mRv != 0) chk(int'(rspCode) == mCode, tag, "rspCode", int'(rspCode), mCode);
    chk(int'(abortSticky) == mSticky, tag, "abortSticky", int'(abortSticky), mSticky);
    chk(int'(priBus) == mPri && int'(secBus) == mSec && int'(subBus) == mSub, tag, "busRegs",
        int'(priBus) * 65536 + int'(secBus) * 256 + int'(subBus), mPri * 65536 + mSec * 256 + mSub);
  endtask

  task automatic wr(input int sel, input int wd, input string tag);
    step(0, 0, 0, 1, sel, wd, tag);
  endtask

  task automatic rq(input int bus, input int dev, input string tag);
    step(1, bus, dev, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rspValid == 1'b0, "R1", "rspValid", int'(rspValid), 0);
    chk(abortSticky == 1'b0, "R1", "abortSticky", int'(abortSticky), 0);
    chk(priBus == 0 && secBus == 0 && subBus == 0, "R1", "busRegs",
        int'(priBus) + int'(secBus) + int'(subBus), 0);
    rstN = 1'b1;
    @(negedge clk);

    rq(0, 0, "R3");            // secondary is 0 after reset
    rq(5, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R8"); // idle gives no response

    wr(0, 3, "R2"); wr(1, 10, "R2"); wr(2, 20, "R2");

    rq(10, 0, "R3");
    rq(10, 7, "R7");
    wr(3, 0, "R10");           // bit 0 clear: flag stays
    wr(3, 254, "R10");
    rq(12, 0, "R10");          // a normal request does not clear it
    wr(3, 1, "R10");           // clears

    rq(11, 3, "R4"); rq(20, 31, "R4");
    rq(9, 0, "R5"); rq(21, 0, "R5"); rq(3, 0, "R5"); rq(255, 0, "R5");

    // R8: back-to-back requests
    rq(10, 0, "R8"); rq(15, 1, "R8"); rq(10, 31, "R8"); rq(30, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    wr(3, 1, "R10");

    // R9: request held across a write, then sees the new secondary
    step(1, 40, 0, 1, 1, 40, "R9");
    rq(40, 0, "R9");

    // R6: inverted window
    wr(1, 50, "R6"); wr(2, 30, "R6");
    rq(50, 0, "R6"); rq(40, 0, "R6"); rq(51, 0, "R6"); rq(30, 0, "R6");

    // R4: full sweep against one window
    wr(1, 100, "R4"); wr(2, 200, "R4"); wr(3, 1, "R4");
    for (int b = 0; b < 256; b++) rq(b, b % 2, "R4");

    // Window at the top of the range
    wr(1, 255, "R3"); wr(2, 255, "R3"); wr(3, 1, "R3");
    rq(255, 0, "R3"); rq(254, 0, "R5"); rq(0, 0, "R5");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule